// File: doc/BRIEF.md
# Cascadable Shift-Register Bus Comparator

This block is one byte-wide slice that holds a value in a register and compares it, at all times, against the value on a shared bidirectional data bus. The register can be loaded from the bus or shifted serially. It can also keep its value, or drive its contents back onto the bus. A two-bit operation select chooses the operation. Register changes happen only on the rising clock edge. The comparison result and its flags are combinational.

The three result flags, equal, greater and less, model open-collector outputs. A flag that is not asserted pulls low, and a released flag reads high. Several slices can therefore be combined into a wider word by AND-ing like flags. A single pin carries serial data in shift mode. In all other modes it carries status priority down the chain. An outgoing priority pin is high only when this slice received priority and its bytes match. That pin also feeds the slice's own status enable, so the first unequal byte from the top owns the greater and less flags. A compare-mode input selects signed two's-complement ordering. Only the most significant slice of a chain sets it.

Operations (the `sel` encoding): OP_HOLD = 2'b00 keeps the register. OP_SHIFT = 2'b01 shifts toward the MSB on the next edge. OP_LOAD = 2'b10 captures the bus on the edge. OP_READ = 2'b11 drives the register onto the bus and keeps its value.

Top module: `cmp_shift_slice`

## Requirements
- R1: An active-low asynchronous reset clears the register to zero, and a read then returns 0.
- R2: With sel = 2'b10 the register takes the bus value at the rising edge.
- R3: With sel = 2'b00 or 2'b11 the register keeps its value. The slice drives the bus with the register value only while sel = 2'b11, and otherwise leaves the bus undriven.
- R4: With sel = 2'b01 each edge moves bit i to bit i+1 and loads bit 0 from `pri_si`. During shift, `pri_so` shows the register MSB.
- R5: With `stat_en_n` low, `eq_o` is high exactly when the register equals the bus, and low otherwise.
- R6: With `stat_en_n` low, `pri_si` high and `twos_mode` low, `gt_o` is high if the register is greater than the bus as unsigned, else low. `lt_o` mirrors this, so exactly one flag is high.
- R7: With `twos_mode` high, greater and less follow signed two's-complement ordering.
- R8: With `stat_en_n` high, all three flags are released high.
- R9: With `pri_si` low, `gt_o` and `lt_o` are released high.
- R10: Outside shift mode, `pri_so` = `pri_si` AND (register equals bus).
- R11: A chain of slices has each `pri_so` driving the next lower `pri_si` and its own `stat_en_n`. The top `pri_si` is high, the bottom `stat_en_n` is low, and `twos_mode` is set on the top slice only. The AND of like flags then gives the compare of the full-width word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Operation select: 00 hold, 01 shift, 10 load, 11 read |
| pri_si | input | 1 | Serial data in (shift) or status priority in |
| stat_en_n | input | 1 | Active-low status enable for the three flags |
| twos_mode | input | 1 | 0 unsigned compare, 1 two's-complement compare |
| bus | inout | W | Bidirectional data bus, driven only in read |
| pri_so | output | 1 | Serial data out (MSB) or status priority out |
| eq_o | output | 1 | Register equals bus (released high) |
| gt_o | output | 1 | Register greater than bus (released high) |
| lt_o | output | 1 | Register less than bus (released high) |

## Verification
The flag assertions assume that every bus bit holds a known level at each clock edge after reset. Either the bench or, in read mode, the slice itself drives the bus. The bench therefore releases the bus only on read cycles and drives a defined value on all others, including shift cycles. Serial and status-enable levels always come from bench registers or from a neighbour slice's output, never from a floating net. Full-width comparisons are checked only while the chain is tied as R11 requires.

// File: rtl/cmpslice_pkg.sv
package cmpslice_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_SHIFT = 2'b01,
        OP_LOAD  = 2'b10,
        OP_READ  = 2'b11
    } slice_op_e;
endpackage

// File: rtl/slice_reg.sv
module slice_reg
    import cmpslice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slice_op_e    op,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    logic [W-1:0] q_nx;

    // next-value process
    always_comb begin
        q_nx = q;
        unique case (op)
            OP_HOLD:  q_nx = q;
            OP_SHIFT: q_nx = {q[W-2:0], ser_in};
            OP_LOAD:  q_nx = par_in;
            OP_READ:  q_nx = q;
            default:  q_nx = q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nx;
    end

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_READ) |=> $stable(q));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (q == $past(par_in)));

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (q == {$past(q[W-2:0]), $past(ser_in)}));
endmodule

// File: rtl/slice_cmp.sv
module slice_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         twos,
    output logic         eq,
    output logic         gt,
    output logic         lt
);
    localparam int MSB = W - 1;
    logic [W-1:0] ka, kb;

    // flipping the sign bit maps signed order onto unsigned order
    always_comb begin
        ka = {a[MSB] ^ twos, a[MSB-1:0]};
        kb = {b[MSB] ^ twos, b[MSB-1:0]};
        eq = (ka == kb);
        gt = (ka > kb);
        lt = (ka < kb);
    end
endmodule

// File: rtl/slice_status.sv
module slice_status
    import cmpslice_pkg::*;
(
    input  slice_op_e op,
    input  logic      eq,
    input  logic      gt,
    input  logic      lt,
    input  logic      pri_in,
    input  logic      se_n,
    input  logic      q_msb,
    output logic      pri_out,
    output logic      eq_o,
    output logic      gt_o,
    output logic      lt_o
);
    always_comb begin
        unique case (op)
            OP_SHIFT: pri_out = q_msb;
            default:  pri_out = pri_in & eq;
        endcase
        eq_o = se_n | eq;
        gt_o = se_n | ~pri_in | gt;
        lt_o = se_n | ~pri_in | lt;
    end
endmodule

// File: rtl/cmp_shift_slice.sv
module cmp_shift_slice
    import cmpslice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         pri_si,
    input  logic         stat_en_n,
    input  logic         twos_mode,
    inout  wire  [W-1:0] bus,
    output logic         pri_so,
    output logic         eq_o,
    output logic         gt_o,
    output logic         lt_o
);
    localparam int MSB = W - 1;

    slice_op_e    op;
    logic [W-1:0] q;
    logic         c_eq, c_gt, c_lt;

    assign op  = slice_op_e'(sel);
    assign bus = (op == OP_READ) ? q : 'z;

    slice_reg #(.W(W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_in (pri_si),
        .par_in (bus),
        .q      (q)
    );

    slice_cmp #(.W(W)) u_cmp (
        .a    (q),
        .b    (bus),
        .twos (twos_mode),
        .eq   (c_eq),
        .gt   (c_gt),
        .lt   (c_lt)
    );

    slice_status u_stat (
        .op      (op),
        .eq      (c_eq),
        .gt      (c_gt),
        .lt      (c_lt),
        .pri_in  (pri_si),
        .se_n    (stat_en_n),
        .q_msb   (q[MSB]),
        .pri_out (pri_so),
        .eq_o    (eq_o),
        .gt_o    (gt_o),
        .lt_o    (lt_o)
    );

    p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en_n |-> (eq_o && gt_o && lt_o));

    p_prio_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_si && !stat_en_n) |-> (gt_o && lt_o));

    p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_si && !stat_en_n) |-> ($countones({eq_o, gt_o, lt_o}) == 1));

    p_read_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !stat_en_n) |-> eq_o);
endmodule

// File: tb/sim_cmp_shift_slice.sv
module sim_cmp_shift_slice;
    localparam int W = 8;
    localparam int N = 3;
    localparam int T = 8;
    localparam int NW = N * W;

    logic clk = 1'b0;
    always #(T/2) clk = ~clk;

    logic          rst_n;
    logic [1:0]    sel;
    logic          tb_si, tb_se0, tb_mode;
    logic [NW-1:0] drv;
    logic          drv_en;
    wire  [NW-1:0] bus;
    wire  [N:0]    chain;
    wire  [N-1:0]  se, eq_s, gt_s, lt_s;

    assign bus      = drv_en ? drv : 'z;
    assign chain[N] = tb_si;

    for (genvar k = 0; k < N; k++) begin : g_slice
        assign se[k] = (k == 0) ? tb_se0 : chain[k];
        cmp_shift_slice #(.W(W)) u0 (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel),
            .pri_si    (chain[k+1]),
            .stat_en_n (se[k]),
            .twos_mode ((k == N-1) ? tb_mode : 1'b0),
            .bus       (bus[k*W +: W]),
            .pri_so    (chain[k]),
            .eq_o      (eq_s[k]),
            .gt_o      (gt_s[k]),
            .lt_o      (lt_s[k])
        );
    end

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] m [N];

    task automatic check(input bit ok, input string tag, input logic [NW-1:0] act,
                         input logic [NW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NW-1:0] model_word();
        logic [NW-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = m[k];
        return v;
    endfunction

    task automatic cycle(input logic [1:0] s, input logic [NW-1:0] b, input logic si,
                         input logic md, input logic se0, input string rtag);
        logic sk, sok, eqk, gk, lk, sek;
        logic [W-1:0] bk;
        logic [2:0] exp3;
        logic [NW-1:0] mw;
        logic [W-1:0] old [N];
        string tg;
        @(negedge clk);
        sel = s; drv = b; drv_en = (s != 2'b11); tb_si = si; tb_mode = md; tb_se0 = se0;
        #2;
        mw = model_word();
        if (s == 2'b11) begin
            check(bus === mw, rtag, bus, mw);
        end else if (s == 2'b01) begin
            check(chain[N-1] === m[N-1][W-1], "R4", {23'd0, chain[N-1]}, {23'd0, m[N-1][W-1]});
        end else begin
            sk = si;
            for (int k = N-1; k >= 0; k--) begin
                bk  = b[k*W +: W];
                eqk = (m[k] == bk);
                sok = sk & eqk;
                sek = (k == 0) ? se0 : sok;
                if (k == N-1 && md) begin
                    gk = $signed(m[k]) > $signed(bk);
                    lk = $signed(m[k]) < $signed(bk);
                end else begin
                    gk = m[k] > bk;
                    lk = m[k] < bk;
                end
                exp3 = sek ? 3'b111 : {eqk, ~sk | gk, ~sk | lk};
                if (sek)                  tg = "R8";
                else if (!sk)             tg = "R9";
                else if (k == N-1 && md)  tg = "R7";
                else if (eqk)             tg = "R5";
                else                      tg = "R6";
                check({eq_s[k], gt_s[k], lt_s[k]} === exp3, tg,
                      {21'd0, eq_s[k], gt_s[k], lt_s[k]}, {21'd0, exp3});
                check(chain[k] === sok, "R10", {23'd0, chain[k]}, {23'd0, sok});
                sk = sok;
            end
            if (si && !se0) begin
                exp3[2] = (mw == b);
                exp3[1] = md ? ($signed(mw) > $signed(b)) : (mw > b);
                exp3[0] = md ? ($signed(mw) < $signed(b)) : (mw < b);
                check({&eq_s, &gt_s, &lt_s} === exp3, "R11",
                      {21'd0, &eq_s, &gt_s, &lt_s}, {21'd0, exp3});
            end
        end
        @(posedge clk);
        for (int k = 0; k < N; k++) old[k] = m[k];
        if (s == 2'b10) begin
            for (int k = 0; k < N; k++) m[k] = b[k*W +: W];
        end else if (s == 2'b01) begin
            m[N-1] = {old[N-1][W-2:0], si};
            for (int k = N-2; k >= 0; k--) m[k] = {old[k][W-2:0], old[k+1][W-1]};
        end
    endtask

    initial begin
        #(T * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [NW-1:0] a, b;
        rst_n = 1'b0; sel = 2'b00; drv = '0; drv_en = 1'b1;
        tb_si = 1'b1; tb_se0 = 1'b0; tb_mode = 1'b0;
        for (int k = 0; k < N; k++) m[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        cycle(2'b11, '0, 1'b1, 1'b0, 1'b0, "R1");       // R1 reset value via read

        a = 24'h5a3c81;
        cycle(2'b10, a, 1'b1, 1'b0, 1'b0, "R2");
        cycle(2'b11, '0, 1'b1, 1'b0, 1'b0, "R2");       // R2 loaded value read back
        cycle(2'b11, '0, 1'b1, 1'b0, 1'b0, "R3");       // R3 read keeps value

        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                a = NW'($urandom);
                cycle(2'b10, a, 1'b1, 1'b0, 1'b0, "R2");
            end
            case (i % 4)
                0: b = a;
                1: b = {a[NW-1:W], W'($urandom)};
                2: b = {a[NW-1:2*W], W'($urandom), a[W-1:0]};
                default: b = NW'($urandom);
            endcase
            cycle(2'b00, b, 1'b1, i[3], 1'b0, "R3");
        end
        cycle(2'b11, '0, 1'b1, 1'b0, 1'b0, "R3");       // R3 hold kept value

        // sign boundary, both modes (R7, R11)
        cycle(2'b10, 24'h800000, 1'b1, 1'b0, 1'b0, "R2");
        cycle(2'b00, 24'h7fffff, 1'b1, 1'b0, 1'b0, "R6");
        cycle(2'b00, 24'h7fffff, 1'b1, 1'b1, 1'b0, "R7");
        cycle(2'b00, 24'h800001, 1'b1, 1'b1, 1'b0, "R7");

        // R4 serial shift through the chain
        for (int i = 0; i < 14; i++)
            cycle(2'b01, NW'($urandom), 1'($urandom), 1'b0, 1'b0, "R4");
        cycle(2'b11, '0, 1'b1, 1'b0, 1'b0, "R4");

        // R8 bottom slice status disabled
        a = 24'h123456;
        cycle(2'b10, a, 1'b1, 1'b0, 1'b0, "R2");
        cycle(2'b00, 24'h123499, 1'b1, 1'b0, 1'b1, "R8");
        cycle(2'b00, 24'h123456, 1'b1, 1'b0, 1'b1, "R8");

        // R9 top priority low, top byte unequal
        cycle(2'b00, 24'h993456, 1'b0, 1'b0, 1'b0, "R9");
        cycle(2'b00, 24'h003456, 1'b0, 1'b1, 1'b0, "R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule